// File: doc/BRIEF.md
# Tiny 8-bit Multi-Cycle Processor Core

This block is a small multi-cycle processor for an eight-opcode, 8-bit instruction set. It keeps a program counter, four general registers (R0 to R3) and a three-flag condition code (negative, zero, positive). Each instruction is fetched from a synchronous instruction port, latched and decoded, then executed. Loads take one extra cycle to collect data from a synchronous data port. Stores drive address, write data and a one-cycle write strobe on that same port.

Every instruction byte holds the opcode in bits 7:5. Bits 4:3 name register A and bits 1:0 name register B. Bit 2 is the operand-select bit for ADD and AND. The conditional branch jumps to an absolute address read from a register. Load-immediate and address-generation instructions always write R0. A halt input stops the core at the next instruction boundary.

The control sequence has four named states. FETCH presents the PC on the instruction port. It goes to DECODE, or stays in FETCH while halt is high. DECODE latches the instruction and advances the PC, then goes to EXEC. EXEC goes to MEM for a load and back to FETCH for every other opcode. MEM writes the loaded value and returns to FETCH.

Top module: `tiny8_core`

## Requirements
- R1: Synchronous reset clears the PC and all four registers and sets the condition code to zero. The flag vector is {N,Z,P}, so zero is 3'b010. After reset the first fetch address is 0.
- R2: Opcode encoding in bits 7:5 is as follows: 000 add, 001 and, 010 branch, 011 load-immediate, 100 address-generate, 101 load, 110 store, 111 invert. Each instruction uses FETCH, DECODE and EXEC, plus MEM for a load. The PC increments by 1 in DECODE.
- R3: Add and and write RA op operand2 into RA (bits 4:3). Operand2 is register RB (bits 1:0) when bit 2 is 0. When bit 2 is 1, operand2 is bits 1:0 sign-extended, and RB is not read.
- R4: Invert writes the bitwise complement of RA into RA, whatever bits 2:0 hold.
- R5: Load-immediate writes bits 4:0 sign-extended into R0. Address-generate writes (PC of the instruction + 1) + sign-extended bits 4:0 into R0.
- R6: A load writes mem[RB] into RA, and a store writes RA to address RB. In both, bit 2 has no effect. A store drives the write strobe for exactly one cycle.
- R7: Add, and, invert, load and load-immediate each set exactly one flag from the value written: N if bit 7 is 1, Z if the value is 0, otherwise P. Branch, store and address-generate leave the flags unchanged. Exactly one flag is set at all times.
- R8: A branch (bits 4:2 = n,z,p mask; bits 1:0 = base register) loads the PC with the base register value when any mask bit matches the set flag. Otherwise execution goes on at the next address. Mask 111 always jumps and mask 000 never does.
- R9: While halt is high in FETCH, the PC holds and no instruction starts. An instruction already past FETCH completes. Lowering halt resumes execution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Stops the core at the next instruction boundary |
| imem_addr | output | 8 | Instruction fetch address (the PC) |
| imem_rdata | input | 8 | Instruction byte, valid the cycle after the address |
| dmem_addr | output | 8 | Data address (base register value) |
| dmem_wdata | output | 8 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle |
| dmem_rdata | input | 8 | Load data, valid the cycle after the address |

## Verification
The overlap that needs care is halt rising while an instruction is in flight. The bench raises halt at fixed cycle counts that land in DECODE, EXEC or MEM as well as in FETCH. It judges the result by where the PC settles: on the loop address that a completed branch leads to, never partway through an instruction. A second overlap is a store followed directly by a flag-testing branch. Every table vector places a store between the flag-setting instruction and the branch. Whether the branch is taken or falls through then shows that the store's cycle neither cleared nor changed the flags.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_AND = 3'b001,
        OP_BRR = 3'b010,
        OP_LDI = 3'b011,
        OP_LEA = 3'b100,
        OP_LD  = 3'b101,
        OP_ST  = 3'b110,
        OP_NOT = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_MEM    = 2'd3
    } state_e;

    // instruction byte layout: opcode, register A, select bit, register B
    typedef struct packed {
        opcode_e    op;
        logic [1:0] ra;
        logic       sel;
        logic [1:0] rb;
    } instr_t;

    localparam logic [2:0] FLAG_N = 3'b100;
    localparam logic [2:0] FLAG_Z = 3'b010;
    localparam logic [2:0] FLAG_P = 3'b001;

endpackage

// File: rtl/tiny8_regfile.sv
module tiny8_regfile #(
    parameter int DATA_W = 8,
    parameter int NREG   = 4,
    localparam int RA_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RA_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RA_W-1:0]   raddr_a,
    input  logic [RA_W-1:0]   raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && (waddr == RA_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/tiny8_alu.sv
module tiny8_alu
    import tiny8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_AND:  y = a & b;
            OP_NOT:  y = ~a;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/tiny8_ctrl.sv
module tiny8_ctrl
    import tiny8_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    halt,
    input  opcode_e op,
    output state_e  state,
    output logic    ir_load,
    output logic    exec_en,
    output logic    mem_wb
);

    state_e state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    // next state and per-state strobes
    always_comb begin
        state_nx = state;
        ir_load  = 1'b0;
        exec_en  = 1'b0;
        mem_wb   = 1'b0;
        unique case (state)
            ST_FETCH: begin
                state_nx = halt ? ST_FETCH : ST_DECODE;
            end
            ST_DECODE: begin
                ir_load  = 1'b1;
                state_nx = ST_EXEC;
            end
            ST_EXEC: begin
                exec_en  = 1'b1;
                state_nx = (op == OP_LD) ? ST_MEM : ST_FETCH;
            end
            ST_MEM: begin
                mem_wb   = 1'b1;
                state_nx = ST_FETCH;
            end
        endcase
    end

endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
    import tiny8_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int NREG  = 4,
    localparam int IMM_W = 5,
    localparam int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    output logic [DATA_W-1:0] imem_addr,
    input  logic [7:0]        imem_rdata,
    output logic [DATA_W-1:0] dmem_addr,
    output logic [DATA_W-1:0] dmem_wdata,
    output logic              dmem_we,
    input  logic [DATA_W-1:0] dmem_rdata
);

    state_e            state;
    instr_t            ir;
    logic [DATA_W-1:0] pc;
    logic [2:0]        flags;
    logic              ir_load, exec_en, mem_wb;

    logic [DATA_W-1:0] rd_a, rd_b, opnd_b, alu_y, imm5, wb_data;
    logic [1:0]        wb_addr;
    logic              wb_en, flag_upd, br_taken;

    tiny8_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .halt    (halt),
        .op      (ir.op),
        .state   (state),
        .ir_load (ir_load),
        .exec_en (exec_en),
        .mem_wb  (mem_wb)
    );

    tiny8_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wb_en),
        .waddr   (wb_addr),
        .wdata   (wb_data),
        .raddr_a (ir.ra),
        .raddr_b (ir.rb),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    // operand select: register B or short sign-extended constant
    assign opnd_b = ir.sel ? {{(DATA_W-SEL_W){ir.rb[1]}}, ir.rb} : rd_b;
    assign imm5   = {{(DATA_W-IMM_W){ir.ra[1]}}, ir.ra, ir.sel, ir.rb};

    tiny8_alu #(.DATA_W(DATA_W)) u_alu (
        .op (ir.op),
        .a  (rd_a),
        .b  (opnd_b),
        .y  (alu_y)
    );

    assign br_taken = |({ir.ra, ir.sel} & flags);

    // write-back selection
    always_comb begin
        wb_en    = 1'b0;
        wb_addr  = ir.ra;
        wb_data  = alu_y;
        flag_upd = 1'b0;
        if (exec_en) begin
            unique case (ir.op)
                OP_ADD, OP_AND, OP_NOT: begin
                    wb_en    = 1'b1;
                    flag_upd = 1'b1;
                end
                OP_LDI: begin
                    wb_en    = 1'b1;
                    wb_addr  = 2'd0;
                    wb_data  = imm5;
                    flag_upd = 1'b1;
                end
                OP_LEA: begin
                    wb_en    = 1'b1;
                    wb_addr  = 2'd0;
                    wb_data  = pc + imm5;
                end
                OP_BRR, OP_LD, OP_ST: begin
                    wb_en    = 1'b0;
                end
            endcase
        end else if (mem_wb) begin
            wb_en    = 1'b1;
            wb_data  = dmem_rdata;
            flag_upd = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir <= '0;
        end else if (ir_load) begin
            ir <= instr_t'(imem_rdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (ir_load) begin
            pc <= pc + DATA_W'(1);
        end else if (exec_en && (ir.op == OP_BRR) && br_taken) begin
            pc <= rd_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= FLAG_Z;
        end else if (flag_upd) begin
            if (wb_data[DATA_W-1]) begin
                flags <= FLAG_N;
            end else if (wb_data == '0) begin
                flags <= FLAG_Z;
            end else begin
                flags <= FLAG_P;
            end
        end
    end

    assign imem_addr  = pc;
    assign dmem_addr  = rd_b;
    assign dmem_wdata = rd_a;
    assign dmem_we    = exec_en && (ir.op == OP_ST);

endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk
    import tiny8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              halt,
    input state_e            state,
    input logic [DATA_W-1:0] pc,
    input logic [2:0]        flags,
    input logic              dmem_we
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == '0 && flags == FLAG_Z && state == ST_FETCH));

    assert_decode_to_exec_R2: assert property (@(posedge clk) disable iff (rst)
        state == ST_DECODE |=> state == ST_EXEC);

    assert_mem_follows_exec_R2: assert property (@(posedge clk) disable iff (rst)
        state == ST_MEM |-> $past(state) == ST_EXEC);

    assert_fetch_keeps_pc_R2: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |=> $stable(pc));

    assert_store_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);

    assert_flags_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(flags) == 1);

    assert_store_keeps_flags_R7: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> $stable(flags));

    assert_halt_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && halt) |=> (state == ST_FETCH && $stable(pc)));

endmodule

bind tiny8_core tiny8_core_chk #(.DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .halt    (halt),
    .state   (state),
    .pc      (pc),
    .flags   (flags),
    .dmem_we (dmem_we)
);

// File: tb/test_tiny8_core.sv
`timescale 1ns/1ps
module test_tiny8_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt = 1'b1;
    logic [7:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic       dmem_we;

    logic [7:0] imem [256];
    logic [7:0] dmem [256];

    int tests = 0;
    int fails = 0;

    logic       st_seen;
    logic [7:0] st_addr, st_data, first_addr;

    always #10 clk = ~clk;

    tiny8_core i_tiny8_core (
        .clk        (clk),
        .rst        (rst),
        .halt       (halt),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    // synchronous memories
    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr];
        dmem_rdata <= dmem[dmem_addr];
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    // first store after reset
    always @(negedge clk) begin
        if (rst) begin
            st_seen <= 1'b0;
        end else if (dmem_we && !st_seen) begin
            st_seen <= 1'b1;
            st_addr <= dmem_addr;
            st_data <= dmem_wdata;
        end
    end

    // fields: init R1, init R2, test instr, result, branch mask, taken
    localparam int NV = 11;
    localparam logic [35:0] VECS [NV] = '{
        {8'h05, 8'h03, 8'h0A, 8'h08, 3'b001, 1'b1},
        {8'h01, 8'h00, 8'h0F, 8'h00, 3'b010, 1'b1},
        {8'h7F, 8'h01, 8'h0A, 8'h80, 3'b100, 1'b1},
        {8'h7F, 8'h01, 8'h0A, 8'h80, 3'b011, 1'b0},
        {8'hF0, 8'h3C, 8'h2A, 8'h30, 3'b001, 1'b1},
        {8'h96, 8'h00, 8'h2D, 8'h00, 3'b101, 1'b0},
        {8'h83, 8'h00, 8'h2E, 8'h82, 3'b100, 1'b1},
        {8'h0F, 8'h00, 8'hED, 8'hF0, 3'b111, 1'b1},
        {8'hFF, 8'h00, 8'hE8, 8'h00, 3'b000, 1'b0},
        {8'h05, 8'h64, 8'h0E, 8'h03, 3'b001, 1'b1},
        {8'h40, 8'h00, 8'h09, 8'h80, 3'b110, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mems();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 8'h40;
            dmem[i] = 8'h00;
        end
    endtask

    task automatic run_prog(input int cycles);
        @(negedge clk);
        rst  = 1'b1;
        halt = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        first_addr = imem_addr;
        repeat (cycles) @(negedge clk);
        halt = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        clear_mems();
        repeat (3) @(negedge clk);

        // table: R2 R3 R4 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            clear_mems();
            dmem[0] = VECS[v][35:28];
            dmem[1] = VECS[v][27:20];
            imem[0] = 8'hA8;
            imem[1] = 8'h61;
            imem[2] = 8'hB0;
            imem[3] = 8'h6C;
            imem[4] = VECS[v][19:12];
            imem[5] = 8'hCB;
            imem[6] = {3'b010, VECS[v][3:1], 2'b00};
            imem[7] = 8'h67;
            imem[8] = 8'h5C;
            imem[12] = 8'h5C;
            run_prog(50);
            check($sformatf("R3/R4 vec%0d result", v), {st_seen, st_data}, {1'b1, VECS[v][11:4]});
            check($sformatf("R6 vec%0d store addr", v), st_addr, 8'h00);
            check($sformatf("R7/R8 vec%0d branch", v), imem_addr == 8'd12, VECS[v][0]);
        end

        // R1: reset state, zero registers, Z flag
        clear_mems();
        imem[0] = 8'hD3; imem[1] = 8'h4B; imem[2] = 8'h6F; imem[3] = 8'h5C; imem[15] = 8'h5C;
        run_prog(40);
        check("R1 first fetch address", first_addr, 8'h00);
        check("R1 register cleared", {st_seen, st_data}, {1'b1, 8'h00});
        check("R1 store address", st_addr, 8'h00);
        check("R1 Z set after reset", imem_addr < 8'd2, 1'b1);

        // R5: load-immediate sign extension at both ends
        clear_mems();
        imem[0] = 8'h70; imem[1] = 8'hC3;
        run_prog(20);
        check("R5 ldi -16", {st_seen, st_data}, {1'b1, 8'hF0});
        clear_mems();
        imem[0] = 8'h6F; imem[1] = 8'hC3;
        run_prog(20);
        check("R5 ldi +15", {st_seen, st_data}, {1'b1, 8'h0F});

        // R5 R7: address generation, flags kept at Z
        clear_mems();
        imem[2] = 8'h90; imem[3] = 8'hC3; imem[4] = 8'h4B;
        imem[5] = 8'h6F; imem[6] = 8'h5C; imem[15] = 8'h5C;
        run_prog(50);
        check("R5 lea -16", {st_seen, st_data}, {1'b1, 8'hF3});
        check("R7 lea keeps flags", imem_addr < 8'd5, 1'b1);
        clear_mems();
        imem[2] = 8'h8F; imem[3] = 8'hC3; imem[4] = 8'h4B;
        imem[5] = 8'h6F; imem[6] = 8'h5C; imem[15] = 8'h5C;
        run_prog(50);
        check("R5 lea +15", {st_seen, st_data}, {1'b1, 8'h12});
        check("R7 lea positive keeps Z", imem_addr < 8'd5, 1'b1);

        // R6: bit 2 set on load and store, base register addressing
        clear_mems();
        dmem[0] = 8'h5A;
        imem[0] = 8'hAC; imem[1] = 8'h69; imem[2] = 8'hCC;
        run_prog(30);
        check("R6 load/store data", {st_seen, st_data}, {1'b1, 8'h5A});
        check("R6 store base addr", st_addr, 8'h09);

        // R7: load sets N
        clear_mems();
        dmem[0] = 8'h80;
        imem[0] = 8'hA8; imem[1] = 8'h53; imem[2] = 8'h6F; imem[3] = 8'h5C; imem[15] = 8'h5C;
        run_prog(40);
        check("R7 load sets N", imem_addr < 8'd2, 1'b1);

        // R8: unconditional jump to absolute register value
        clear_mems();
        dmem[0] = 8'hC8;
        imem[0] = 8'hA8; imem[1] = 8'h5D; imem[8'hC8] = 8'h63; imem[8'hC9] = 8'hC3;
        run_prog(40);
        check("R8 absolute jump", {st_seen, st_data}, {1'b1, 8'h03});

        // R9: halt held from reset, then released
        clear_mems();
        imem[0] = 8'hD3;
        @(negedge clk);
        halt = 1'b1;
        rst  = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 halted no store", st_seen, 1'b0);
        check("R9 halted pc", imem_addr, 8'h00);
        halt = 1'b0;
        repeat (20) @(negedge clk);
        check("R9 resume", st_seen, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule